// File: doc/BRIEF.md
# Interlocked Lane Training Sequencer

This block runs link training for one lane adapter. After a training request it steps through four training phases: two lock phases and then two training-sequence phases. In each phase it names the ordered set that the serializer should send, counts the whole sets that the serializer reports as sent, and watches the symbols that the deserializer detects from the link partner. A phase is left only when two conditions both hold. The local side must have sent enough complete sets. The partner must have been heard for enough consecutive matching symbols. Whichever condition is met first is held until the other one is also met.

Every phase has a cycle budget. If the interlock is not closed within that budget, the sequencer abandons the attempt, pulses a retry flag and starts again at the first lock phase with all progress cleared. Once the last phase completes, the block reports the lane as trained and stays there until a new request arrives. A request at any time restarts training from the first lock phase.

Top module: `lane_train_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in idle: `phase` = 0, `tx_os` = 0 (nothing sent), `trained` = 0 and `retry` = 0. The block stays idle until `train_req` is seen.
- R2: When `train_req` is high at a clock edge, the next cycle shows `phase` = 1 (first lock phase), whatever the current phase. All counts and held conditions are cleared at that point.
- R3: A phase is left only when the complete-set count has reached its minimum and the receive condition has been met. Either condition alone keeps the block in the phase.
- R4: In phase 1 the block sends `tx_os` = 1. The minimum is LOCK_TX_MIN complete sets (4 by default), and the receive condition is LOCK_RX_RUN consecutive symbols with code 1 (2 by default).
- R5: Once the receive condition has been met it is held, even if mismatching symbols arrive later, until the phase is left.
- R6: If the set minimum has been reached but the receive condition has not, the block stays in the phase and keeps showing the same `tx_os`.
- R7: A valid symbol (`rx_vld` = 1) whose `rx_sym` differs from the current phase's code resets the consecutive run to zero. A cycle with `rx_vld` = 0 leaves the run unchanged.
- R8: A set counts as complete only if its start strobe (`tx_sos`) was seen in the current phase before its end strobe (`tx_eos`). An end strobe without such a start is not counted.
- R9: The block stays in any training phase for at most TMO_CYCLES cycles. When that budget expires it returns to phase 1 with everything cleared, and `retry` is high for exactly the one cycle in which phase 1 is re-entered.
- R10: The phases follow the order 1, 2, 3, 4, 5. Phases 2, 3 and 4 send and expect codes 2, 3 and 4. Phases 3 and 4 use TS_TX_MIN (8) complete sets and TS_RX_RUN (3) consecutive symbols.
- R11: Phase 5 drives `trained` = 1 and `tx_os` = 0. It holds these values, with no time limit, until `train_req` is seen.
- R12: Counts and held conditions never carry over when a phase is entered, whether by advance, restart or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| train_req | input | 1 | Start or restart training |
| tx_sos | input | 1 | Serializer began an ordered set |
| tx_eos | input | 1 | Serializer finished an ordered set |
| rx_vld | input | 1 | A symbol was detected this cycle |
| rx_sym | input | 3 | Detected symbol code (1..4 match phase codes; other values mismatch) |
| tx_os | output | 3 | Ordered-set code to send (0 = none) |
| phase | output | 3 | Current phase: 0 idle, 1..4 training, 5 trained |
| trained | output | 1 | Lane trained |
| retry | output | 1 | One-cycle pulse on timeout restart |

## Verification
The interlock is driven with receive matches that come well before the sends, with sends that complete while the partner stays silent, and with both arriving together. These patterns show that an early receive result is held and that a finished send count alone never advances the phase. Runs broken by a foreign symbol are set against runs split only by idle cycles, which separates a reset of the run from a pause. End strobes without a start show that only whole sets are counted. A restart after partial progress shows that nothing is carried into the new attempt. Timeouts are forced from the first and from the second phase, and their exact cycle count is checked.

// File: rtl/ltr_pkg.sv
package ltr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LOCK1 = 3'd1,
        PH_LOCK2 = 3'd2,
        PH_TRN1  = 3'd3,
        PH_TRN2  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    localparam logic [2:0] OS_NONE  = 3'd0;
    localparam logic [2:0] OS_LOCKA = 3'd1;
    localparam logic [2:0] OS_LOCKB = 3'd2;
    localparam logic [2:0] OS_TRNA  = 3'd3;
    localparam logic [2:0] OS_TRNB  = 3'd4;

    function automatic logic in_training(input phase_e p);
        return (p == PH_LOCK1) || (p == PH_LOCK2) || (p == PH_TRN1) || (p == PH_TRN2);
    endfunction

    function automatic logic is_lock(input phase_e p);
        return (p == PH_LOCK1) || (p == PH_LOCK2);
    endfunction

    function automatic logic [2:0] os_for(input phase_e p);
        case (p)
            PH_LOCK1: return OS_LOCKA;
            PH_LOCK2: return OS_LOCKB;
            PH_TRN1:  return OS_TRNA;
            PH_TRN2:  return OS_TRNB;
            default:  return OS_NONE;
        endcase
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_LOCK1: return PH_LOCK2;
            PH_LOCK2: return PH_TRN1;
            PH_TRN1:  return PH_TRN2;
            PH_TRN2:  return PH_DONE;
            default:  return p;
        endcase
    endfunction

endpackage

// File: rtl/ltr_tx_tally.sv
module ltr_tx_tally #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         sos,
    input  logic         eos,
    output logic [W-1:0] cnt
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            if (eos && armed && (cnt != '1))
                cnt <= cnt + 1'b1;
            if (sos)
                armed <= 1'b1;
            else if (eos)
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/ltr_rx_run.sv
module ltr_rx_run #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         vld,
    input  logic         hit,
    input  logic [W-1:0] need,
    output logic         met
);
    logic [W-1:0] run;
    logic [W:0]   run_inc;

    assign run_inc = {1'b0, run} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run <= '0;
            met <= 1'b0;
        end else if (vld) begin
            if (hit) begin
                if (run_inc >= {1'b0, need}) begin
                    met <= 1'b1;
                    run <= need;
                end else begin
                    run <= run_inc[W-1:0];
                end
            end else begin
                run <= '0;
            end
        end
    end
endmodule

// File: rtl/ltr_watchdog.sv
module ltr_watchdog #(
    parameter int W     = 10,
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lane_train_seq.sv
module lane_train_seq
    import ltr_pkg::*;
#(
    parameter int LOCK_TX_MIN = 4,
    parameter int LOCK_RX_RUN = 2,
    parameter int TS_TX_MIN   = 8,
    parameter int TS_RX_RUN   = 3,
    parameter int TMO_CYCLES  = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       train_req,
    input  logic       tx_sos,
    input  logic       tx_eos,
    input  logic       rx_vld,
    input  logic [2:0] rx_sym,
    output logic [2:0] tx_os,
    output logic [2:0] phase,
    output logic       trained,
    output logic       retry
);
    localparam int TX_MAX = (LOCK_TX_MIN > TS_TX_MIN) ? LOCK_TX_MIN : TS_TX_MIN;
    localparam int RX_MAX = (LOCK_RX_RUN > TS_RX_RUN) ? LOCK_RX_RUN : TS_RX_RUN;
    localparam int TXC_W  = $clog2(TX_MAX + 1);
    localparam int RUN_W  = $clog2(RX_MAX + 1);
    localparam int TMO_W  = $clog2(TMO_CYCLES + 1);

    phase_e            st_q, st_d;
    logic              act, adv, fire, clr, rx_met, tmo_end, rx_hit;
    logic [TXC_W-1:0]  tx_cnt, tx_need;
    logic [RUN_W-1:0]  rx_need;

    always_comb begin
        if (is_lock(st_q)) begin
            tx_need = TXC_W'(LOCK_TX_MIN);
            rx_need = RUN_W'(LOCK_RX_RUN);
        end else begin
            tx_need = TXC_W'(TS_TX_MIN);
            rx_need = RUN_W'(TS_RX_RUN);
        end
    end

    assign act    = in_training(st_q);
    assign rx_hit = (rx_sym == os_for(st_q));
    assign adv    = act && (tx_cnt >= tx_need) && rx_met;
    assign fire   = act && !adv && tmo_end;
    assign clr    = train_req || adv || fire || !act;

    always_comb begin
        st_d = st_q;
        if (train_req)
            st_d = PH_LOCK1;
        else if (adv)
            st_d = next_phase(st_q);
        else if (fire)
            st_d = PH_LOCK1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_IDLE;
            retry <= 1'b0;
        end else begin
            st_q  <= st_d;
            retry <= fire && !train_req;
        end
    end

    ltr_tx_tally #(.W(TXC_W)) u_tx (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .sos (tx_sos),
        .eos (tx_eos),
        .cnt (tx_cnt)
    );

    ltr_rx_run #(.W(RUN_W)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .vld  (rx_vld),
        .hit  (rx_hit),
        .need (rx_need),
        .met  (rx_met)
    );

    ltr_watchdog #(.W(TMO_W), .LIMIT(TMO_CYCLES)) u_wd (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .expired (tmo_end)
    );

    assign tx_os   = os_for(st_q);
    assign phase   = st_q;
    assign trained = (st_q == PH_DONE);
endmodule

// File: rtl/ltr_chk.sv
module ltr_chk
    import ltr_pkg::*;
#(
    parameter int LOCK_TX_MIN = 4,
    parameter int TS_TX_MIN   = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       train_req,
    input logic       tx_eos,
    input logic [2:0] tx_os,
    input logic [2:0] phase,
    input logic       trained,
    input logic       retry
);
    logic [2:0] last_ph;
    logic [7:0] eos_seen;
    int         need_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_ph  <= 3'd0;
            eos_seen <= 8'd0;
        end else begin
            last_ph <= phase;
            if (phase != last_ph)
                eos_seen <= {7'd0, tx_eos};
            else if (tx_eos && eos_seen != 8'hFF)
                eos_seen <= eos_seen + 8'd1;
        end
    end

    assign need_prev = (last_ph == 3'd1 || last_ph == 3'd2) ? LOCK_TX_MIN : TS_TX_MIN;

    // R1
    reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> (phase == 3'd0 && tx_os == 3'd0 && !retry));

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (last_ph == 3'd0 && phase != 3'd0) |-> phase == 3'd1);

    // R3
    advance_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (last_ph >= 3'd1 && last_ph <= 3'd4 && phase == 3'(last_ph + 3'd1)) |-> (int'(eos_seen) >= need_prev));

    // R9
    retry_lock1_chk: assert property (@(posedge clk) disable iff (rst)
        retry |-> (phase == 3'd1 && !trained));

    // R10
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != last_ph) |-> (phase == 3'(last_ph + 3'd1) || phase == 3'd1));

    // R11
    trained_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(trained) && !$past(train_req)) |-> trained);

endmodule

bind lane_train_seq ltr_chk #(
    .LOCK_TX_MIN (LOCK_TX_MIN),
    .TS_TX_MIN   (TS_TX_MIN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .train_req (train_req),
    .tx_eos    (tx_eos),
    .tx_os     (tx_os),
    .phase     (phase),
    .trained   (trained),
    .retry     (retry)
);

// File: tb/sim_lane_train_seq.sv
`timescale 1ns/1ps
module sim_lane_train_seq;
    localparam int LTX = 4, LRX = 2, TTX = 8, TRX = 3, TMO = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       train_req = 1'b0, tx_sos = 1'b0, tx_eos = 1'b0, rx_vld = 1'b0;
    logic [2:0] rx_sym = 3'd0;
    logic [2:0] tx_os, phase;
    logic       trained, retry;

    int vecs = 0, errs = 0, cyc = 0;
    bit fin = 0, started = 0;

    always #5 clk = ~clk;

    lane_train_seq #(
        .LOCK_TX_MIN(LTX), .LOCK_RX_RUN(LRX), .TS_TX_MIN(TTX), .TS_RX_RUN(TRX), .TMO_CYCLES(TMO)
    ) u0 (
        .clk(clk), .rst(rst), .train_req(train_req), .tx_sos(tx_sos), .tx_eos(tx_eos),
        .rx_vld(rx_vld), .rx_sym(rx_sym), .tx_os(tx_os), .phase(phase),
        .trained(trained), .retry(retry)
    );

    // behavioural reference
    int m_ph = 0, m_txc = 0, m_run = 0, m_tmo = 0;
    bit m_arm = 0, m_ok = 0, m_retry = 0;
    bit b_tr, b_adv, b_fire, b_clr;
    int b_nph;

    function automatic int txmin(int p); return (p <= 2) ? LTX : TTX; endfunction
    function automatic int rxneed(int p); return (p <= 2) ? LRX : TRX; endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_ph = 0; m_txc = 0; m_run = 0; m_tmo = 0; m_arm = 0; m_ok = 0; m_retry = 0;
        end else begin
            b_tr   = (m_ph >= 1 && m_ph <= 4);
            b_adv  = b_tr && (m_txc >= txmin(m_ph)) && m_ok;
            b_fire = b_tr && !b_adv && (m_tmo == TMO - 1);
            b_clr  = train_req || b_adv || b_fire || !b_tr;
            b_nph  = train_req ? 1 : (b_adv ? m_ph + 1 : (b_fire ? 1 : m_ph));
            m_retry = b_fire && !train_req;
            if (b_clr) begin
                m_txc = 0; m_run = 0; m_tmo = 0; m_arm = 0; m_ok = 0;
            end else begin
                if (tx_eos && m_arm) m_txc++;
                if (tx_sos) m_arm = 1; else if (tx_eos) m_arm = 0;
                if (rx_vld) begin
                    if (int'(rx_sym) == m_ph) begin
                        if (m_run + 1 >= rxneed(m_ph)) begin m_ok = 1; m_run = rxneed(m_ph); end
                        else m_run++;
                    end else m_run = 0;
                end
                m_tmo++;
            end
            m_ph = b_nph;
        end
    end

    always @(negedge clk) begin
        if (started && !fin) begin
            vecs++;
            if (int'(phase) != m_ph || int'(tx_os) != ((m_ph >= 1 && m_ph <= 4) ? m_ph : 0) ||
                trained != (m_ph == 5) || retry != m_retry) begin
                errs++;
                $display("FAIL R3/R10 model cycle %0d: phase=%0d tx_os=%0d trained=%0b retry=%0b exp phase=%0d retry=%0b",
                         cyc, phase, tx_os, trained, retry, m_ph, m_retry);
            end
        end
    end

    task automatic chk(input string r, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d", r, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic e, input logic v, input logic [2:0] y, input logic q);
        @(negedge clk);
        cyc++;
        tx_sos = s; tx_eos = e; rx_vld = v; rx_sym = y; train_req = q;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 3'd0, 0);
    endtask

    task automatic sets(input int n, input logic v, input logic [2:0] y);
        for (int i = 0; i < n; i++) begin
            step(1, 0, v, y, 0);
            step(0, 1, v, y, 0);
        end
    endtask

    task automatic sym(input logic [2:0] y);
        step(0, 0, 1, y, 0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            fin = 1; errs++; vecs++;
            $display("FAIL watchdog act=hung exp=done");
            summary();
            $finish;
        end
    end

    int t0;
    bit seen;

    initial begin
        idle(3);
        rst = 1'b0;
        idle(5);
        // R1 idle until request
        chk("R1 phase", phase, 0); chk("R1 tx_os", tx_os, 0);
        chk("R1 trained", trained, 0); chk("R1 retry", retry, 0);

        step(0, 0, 0, 3'd0, 1); idle(1);
        chk("R2 enter lock1", phase, 1); chk("R4 send code", tx_os, 1);

        // R5 early receive, then a foreign symbol
        sym(3'd1); sym(3'd1); sym(3'd6);
        sets(3, 0, 3'd0); idle(3);
        chk("R3 three sets stay", phase, 1);
        sets(1, 0, 3'd0); idle(3);
        chk("R5 R4 latched rx advance", phase, 2);

        // R6 send count met, partner silent
        sets(4, 0, 3'd0); idle(10);
        chk("R6 wait in lock2", phase, 2); chk("R6 keep sending", tx_os, 2);
        // R7 idle gaps do not break the run
        sym(3'd2); idle(2); sym(3'd2); idle(3);
        chk("R7 gap keeps run", phase, 3); chk("R10 ts1 code", tx_os, 3);

        // R8 end strobes without start
        for (int i = 0; i < TTX; i++) step(0, 1, 0, 3'd0, 0);
        sym(3'd3); sym(3'd3); sym(3'd3); idle(3);
        chk("R8 partial sets ignored", phase, 3);
        sets(TTX, 0, 3'd0); idle(3);
        chk("R3 ts1 advance", phase, 4);

        // R7 foreign symbol resets run
        sets(TTX, 0, 3'd0);
        sym(3'd4); sym(3'd4); sym(3'd2); sym(3'd4); sym(3'd4); idle(3);
        chk("R7 broken run stays", phase, 4);
        sym(3'd4); idle(3);
        chk("R10 reach done", phase, 5); chk("R11 trained", trained, 1);
        chk("R11 no send", tx_os, 0);

        idle(TMO + 40);
        chk("R11 hold trained", trained, 1); chk("R11 no timeout", retry, 0);

        // R12 restart clears progress
        step(0, 0, 0, 3'd0, 1); idle(1);
        chk("R2 restart from done", phase, 1); chk("R11 trained drops", trained, 0);
        sets(3, 0, 3'd0); sym(3'd1);
        step(0, 0, 0, 3'd0, 1); t0 = cyc;
        sets(1, 0, 3'd0); sym(3'd1); idle(3);
        chk("R12 no carry over", phase, 1);

        // R9 timeout from lock1
        seen = 0;
        for (int i = 0; i < 3 * TMO && !seen; i++) begin
            idle(1);
            if (retry) seen = 1;
        end
        chk("R9 retry seen", seen, 1);
        chk("R9 timeout cycles", cyc - t0, TMO + 1);
        chk("R9 back to lock1", phase, 1);
        idle(1);
        chk("R9 single pulse", retry, 0);

        // R9 timeout from lock2
        sets(LTX, 1, 3'd1); idle(3);
        chk("R4 simultaneous advance", phase, 2);
        seen = 0;
        for (int i = 0; i < 3 * TMO && !seen; i++) begin
            idle(1);
            if (retry) seen = 1;
        end
        chk("R9 lock2 retry", seen, 1); chk("R9 lock2 to lock1", phase, 1);

        // R1 reset mid training
        sets(2, 0, 3'd0);
        rst = 1'b1; idle(2); rst = 1'b0; idle(2);
        chk("R1 reset phase", phase, 0); chk("R1 reset send", tx_os, 0);

        fin = 1;
        summary();
        $finish;
    end
endmodule